// File: doc/BRIEF.md
# Half-Rate to Double-Data-Rate Output Serialiser with Output-Enable Path

This block is the per-pin output datapath of a general-purpose I/O bank. Core logic runs on a slow clock and hands over four data bits per pin in every slow cycle. The block folds them down to two bits per fast-clock cycle and then drives one bit on each phase of the fast clock. The fast clock is exactly twice the slow clock and rises together with it. The bits leave the block in the order d0, d1, d2, d3.

Each pin also has an output-enable path. It is deliberately simpler than the data path: it has no double-data-rate stage, only a plain fast-clock register. A static parameter gives it one of three shapes. In pass-through mode the core's enable reaches the output with no register at all. In single-register mode the enable passes through the fast register only. In half-rate mode two enable bits per slow cycle are folded down to one per fast cycle and then registered.

A synchronous active-high reset, seen by both clock domains, clears every register and forces the enables low.

Top module: `gpo_ddr_out`

## Requirements
- R1: For pin p, the bits din[p*4+0], din[p*4+1], din[p*4+2], din[p*4+3] appear on dout[p] in that order, one per fast half-period.
- R2: Data captured at a slow rising edge appears on dout in the two fast cycles that begin one and two fast periods after that edge. Bits 0 and 1 come in the first of these cycles and bits 2 and 3 in the second.
- R3: Within a fast cycle, the even-numbered bit of the pair is driven while clk_fast is high and the odd-numbered bit while it is low. Both bits are held in registers loaded on the rising edge.
- R4: With OE_MODE = 0 (pass-through), oe_out[p] equals oe_fr[p] in the same cycle, with no register on the way.
- R5: With OE_MODE = 1 (single register), oe_out[p] shows the value oe_fr[p] had at the previous fast rising edge.
- R6: With OE_MODE = 2 (half-rate), oe_hr[p*2] captured at a slow edge drives oe_out[p] for the whole first fast cycle after that edge, and oe_hr[p*2+1] drives it for the second fast cycle.
- R7: While rst is high, dout and oe_out are 0 from the first fast rising edge at which rst is sampled. In pass-through mode oe_out is 0 at once.
- R8: Each pin uses only its own slices of din, oe_hr and oe_fr. A bit set on one pin never shows up on another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Full-rate clock; its phase selects the bit on dout |
| clk_slow | input | 1 | Half-rate core clock, rising together with clk_fast |
| rst | input | 1 | Synchronous active-high reset for both domains |
| din | input | PINS*4 | Half-rate data, four bits per pin, bit 0 sent first |
| oe_fr | input | PINS | Full-rate output enable, used in modes 0 and 1 |
| oe_hr | input | PINS*2 | Half-rate output enable, two bits per pin, used in mode 2 |
| dout | output | PINS | Double-data-rate data toward the pad |
| oe_out | output | PINS | Output enable toward the pad |

## Verification
A broken slow-to-fast phase tracker swaps the low and high bit pairs or repeats one pair, which breaks the bit order on dout within one slow cycle of the first capture. A fault in the pair registers or in the phase multiplexer shows up as a wrong bit in the very next high or low half-period. A wrong enable stage changes the latency seen at oe_out by exactly one fast cycle, or lets a bit from the wrong half-rate slot through. A scoreboard predicts every half-period and every enable cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

   // Data bits per pin per slow cycle, and bits per fast cycle after folding
   localparam int unsigned HR_DATA_W = 4;
   localparam int unsigned FR_PAIR_W = HR_DATA_W / 2;

   // Enable bits per pin per slow cycle in half-rate mode
   localparam int unsigned HR_OE_W = 2;
   localparam int unsigned FR_OE_W = HR_OE_W / 2;

   // Enable path variants (encoding is part of the block's parameter contract)
   typedef enum int unsigned {
      OE_PASS   = 0,
      OE_SINGLE = 1,
      OE_HALF   = 2
   } oe_shape_e;

endpackage

// File: rtl/gpo_phase_track.sv
// Tells the fast domain which of its two cycles inside a slow cycle is running.
// The slow domain flips a flag on every slow edge. The fast domain keeps a
// delayed copy; a difference marks the first fast cycle after a slow edge.
module gpo_phase_track (
   input  logic clk_slow,
   input  logic clk_fast,
   input  logic rst,
   output logic first_o
);

   logic slow_flag;
   logic fast_seen;

   always_ff @(posedge clk_slow) begin
      if (rst) begin
         slow_flag <= 1'b0;
      end else begin
         slow_flag <= ~slow_flag;
      end
   end

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         fast_seen <= 1'b0;
      end else begin
         fast_seen <= slow_flag;
      end
   end

   assign first_o = slow_flag ^ fast_seen;

endmodule

// File: rtl/gpo_hr_fold.sv
// Half-rate stage: captures IN_W bits on the slow clock and offers the low
// half during the first fast cycle, the high half during the second.
module gpo_hr_fold #(
   parameter int unsigned IN_W  = 4,
   parameter int unsigned OUT_W = 2
) (
   input  logic             clk_slow,
   input  logic             rst,
   input  logic             first_i,
   input  logic [IN_W-1:0]  d_i,
   output logic [OUT_W-1:0] half_o
);

   localparam int unsigned HI_LSB = OUT_W;

   if (IN_W != 2 * OUT_W) begin : g_bad_ratio
      $error("gpo_hr_fold: IN_W must be twice OUT_W");
   end

   logic [IN_W-1:0] cap_q;

   always_ff @(posedge clk_slow) begin
      if (rst) begin
         cap_q <= '0;
      end else begin
         cap_q <= d_i;
      end
   end

   always_comb begin
      if (first_i) begin
         half_o = cap_q[OUT_W-1:0];
      end else begin
         half_o = cap_q[IN_W-1:HI_LSB];
      end
   end

endmodule

// File: rtl/gpo_fr_ddr.sv
// Full-rate stage: both bits are loaded on the rising edge, then the clock
// phase picks the even bit (high) or the odd bit (low).
module gpo_fr_ddr
   import gpo_pkg::*;
(
   input  logic                 clk_fast,
   input  logic                 rst,
   input  logic [FR_PAIR_W-1:0] pair_i,
   output logic                 pad_o
);

   logic even_q;
   logic odd_q;

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         even_q <= 1'b0;
         odd_q  <= 1'b0;
      end else begin
         even_q <= pair_i[0];
         odd_q  <= pair_i[1];
      end
   end

   assign pad_o = clk_fast ? even_q : odd_q;

endmodule

// File: rtl/gpo_oe_path.sv
// Output-enable path for one pin; SHAPE picks one of three structures.
module gpo_oe_path
   import gpo_pkg::*;
#(
   parameter int unsigned SHAPE = 2
) (
   input  logic               clk_slow,
   input  logic               clk_fast,
   input  logic               rst,
   input  logic               first_i,
   input  logic               oe_fr_i,
   input  logic [HR_OE_W-1:0] oe_hr_i,
   output logic               oe_o
);

   if (SHAPE == int'(OE_PASS)) begin : g_pass
      logic unused_inputs;
      assign unused_inputs = ^{clk_slow, clk_fast, first_i, oe_hr_i};
      assign oe_o = oe_fr_i & ~rst;
   end else if (SHAPE == int'(OE_SINGLE)) begin : g_single
      logic unused_inputs;
      logic en_q;
      assign unused_inputs = ^{clk_slow, first_i, oe_hr_i};
      always_ff @(posedge clk_fast) begin
         if (rst) begin
            en_q <= 1'b0;
         end else begin
            en_q <= oe_fr_i;
         end
      end
      assign oe_o = en_q;
   end else if (SHAPE == int'(OE_HALF)) begin : g_half
      logic               unused_inputs;
      logic [FR_OE_W-1:0] folded;
      logic               en_q;
      assign unused_inputs = oe_fr_i;
      gpo_hr_fold #(
         .IN_W  (HR_OE_W),
         .OUT_W (FR_OE_W)
      ) fold_i (
         .clk_slow (clk_slow),
         .rst      (rst),
         .first_i  (first_i),
         .d_i      (oe_hr_i),
         .half_o   (folded)
      );
      always_ff @(posedge clk_fast) begin
         if (rst) begin
            en_q <= 1'b0;
         end else begin
            en_q <= folded[0];
         end
      end
      assign oe_o = en_q;
   end else begin : g_bad_shape
      $error("gpo_oe_path: SHAPE must be 0, 1 or 2");
   end

endmodule

// File: rtl/gpo_ddr_out.sv
// Per-pin half-rate to double-data-rate output datapath with enable path.
module gpo_ddr_out
   import gpo_pkg::*;
#(
   parameter int unsigned PINS    = 2,
   parameter int unsigned OE_MODE = 2
) (
   input  logic                      clk_fast,
   input  logic                      clk_slow,
   input  logic                      rst,
   input  logic [PINS*HR_DATA_W-1:0] din,
   input  logic [PINS-1:0]           oe_fr,
   input  logic [PINS*HR_OE_W-1:0]   oe_hr,
   output logic [PINS-1:0]           dout,
   output logic [PINS-1:0]           oe_out
);

   if (PINS < 1) begin : g_bad_pins
      $error("gpo_ddr_out: PINS must be at least 1");
   end
   if (OE_MODE > 2) begin : g_bad_mode
      $error("gpo_ddr_out: OE_MODE must be 0, 1 or 2");
   end

   // One phase tracker serves every pin
   logic phase_first;

   gpo_phase_track phase_i (
      .clk_slow (clk_slow),
      .clk_fast (clk_fast),
      .rst      (rst),
      .first_o  (phase_first)
   );

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [FR_PAIR_W-1:0] pair;

      gpo_hr_fold #(
         .IN_W  (HR_DATA_W),
         .OUT_W (FR_PAIR_W)
      ) fold_i (
         .clk_slow (clk_slow),
         .rst      (rst),
         .first_i  (phase_first),
         .d_i      (din[p*HR_DATA_W +: HR_DATA_W]),
         .half_o   (pair)
      );

      gpo_fr_ddr ddr_i (
         .clk_fast (clk_fast),
         .rst      (rst),
         .pair_i   (pair),
         .pad_o    (dout[p])
      );

      gpo_oe_path #(
         .SHAPE (OE_MODE)
      ) oe_i (
         .clk_slow (clk_slow),
         .clk_fast (clk_fast),
         .rst      (rst),
         .first_i  (phase_first),
         .oe_fr_i  (oe_fr[p]),
         .oe_hr_i  (oe_hr[p*HR_OE_W +: HR_OE_W]),
         .oe_o     (oe_out[p])
      );
   end

endmodule

// File: rtl/gpo_ddr_out_chk.sv
module gpo_ddr_out_chk #(
   parameter int unsigned PINS    = 2,
   parameter int unsigned OE_MODE = 2
) (
   input logic                clk_fast,
   input logic                clk_slow,
   input logic                rst,
   input logic [PINS*4-1:0]   din,
   input logic [PINS-1:0]     oe_fr,
   input logic [PINS*2-1:0]   oe_hr,
   input logic [PINS-1:0]     dout,
   input logic [PINS-1:0]     oe_out,
   input logic                phase_first
);

   // The first-cycle marker lasts exactly one fast cycle
   AST_PHASE_ALTERNATES: assert property (@(posedge clk_fast) disable iff (rst)
      phase_first |=> !phase_first); // R2

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      // Just before the next slow edge, the low phase carries bit 1 of the previous capture
      AST_DATA_ODD_ORDER: assert property (@(posedge clk_slow) disable iff (rst)
         1'b1 |=> dout[p] == $past(din[p*4+1])); // R1

      if (OE_MODE == 0) begin : g_pass
         AST_OE_PASS_FLOW: assert property (@(posedge clk_fast) disable iff (rst)
            oe_out[p] == oe_fr[p]); // R4
      end else if (OE_MODE == 1) begin : g_single
         AST_OE_ONE_CYCLE: assert property (@(posedge clk_fast) disable iff (rst)
            1'b1 |=> oe_out[p] == $past(oe_fr[p])); // R5
      end else begin : g_half
         AST_OE_HALF_FIRST: assert property (@(posedge clk_slow) disable iff (rst)
            1'b1 |=> oe_out[p] == $past(oe_hr[p*2])); // R6
      end
   end

endmodule

bind gpo_ddr_out gpo_ddr_out_chk #(
   .PINS    (PINS),
   .OE_MODE (OE_MODE)
) chk_i (
   .clk_fast    (clk_fast),
   .clk_slow    (clk_slow),
   .rst         (rst),
   .din         (din),
   .oe_fr       (oe_fr),
   .oe_hr       (oe_hr),
   .dout        (dout),
   .oe_out      (oe_out),
   .phase_first (phase_first)
);

// File: tb/gpo_ddr_out_tb_top.sv
module gpo_ddr_out_tb_top;

   localparam int PINS = 2;

   logic clk_fast = 1'b0;
   logic clk_slow = 1'b0;
   logic rst      = 1'b1;
   logic [PINS*4-1:0] din   = '0;
   logic [PINS-1:0]   oe_fr = '0;
   logic [PINS*2-1:0] oe_hr = '0;

   logic [PINS-1:0] dout, dout_b, dout_p;
   logic [PINS-1:0] oe_out, oe_b, oe_p;

   int cyc    = 0;
   int n_chk  = 0;
   int n_fail = 0;

   // 100 MHz fast clock; the slow clock flips on every fast rising edge
   initial begin
      forever begin
         #5;
         clk_fast = 1'b1;
         clk_slow = ~clk_slow;
         #5;
         clk_fast = 1'b0;
      end
   end

   always @(posedge clk_fast) cyc <= cyc + 1;

   gpo_ddr_out #(.PINS(PINS), .OE_MODE(2)) dut_i (
      .clk_fast (clk_fast), .clk_slow (clk_slow), .rst (rst),
      .din (din), .oe_fr (oe_fr), .oe_hr (oe_hr),
      .dout (dout), .oe_out (oe_out));

   gpo_ddr_out #(.PINS(PINS), .OE_MODE(0)) dut_pass_i (
      .clk_fast (clk_fast), .clk_slow (clk_slow), .rst (rst),
      .din (din), .oe_fr (oe_fr), .oe_hr (oe_hr),
      .dout (dout_b), .oe_out (oe_b));

   gpo_ddr_out #(.PINS(PINS), .OE_MODE(1)) dut_single_i (
      .clk_fast (clk_fast), .clk_slow (clk_slow), .rst (rst),
      .din (din), .oe_fr (oe_fr), .oe_hr (oe_hr),
      .dout (dout_p), .oe_out (oe_p));

   typedef struct {
      int              due;
      logic [PINS-1:0] hi;
      logic [PINS-1:0] lo;
      logic [PINS-1:0] oe;
      string           tag;
   } data_exp_t;

   typedef struct {
      int              due;
      logic [PINS-1:0] oe;
   } oe_exp_t;

   data_exp_t q_data[$];
   oe_exp_t   q_pass[$];
   oe_exp_t   q_single[$];

   task automatic chk(input string req, input logic [PINS-1:0] act,
                      input logic [PINS-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%b exp=%b cyc=%0d", req, act, exp, cyc);
      end
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   // Driver: called 2 ns after a slow rising edge; returns 2 ns after the next one
   task automatic drive_slot(input logic [PINS*4-1:0] d, input logic [PINS*2-1:0] oh,
                             input logic [PINS-1:0] fa, input logic [PINS-1:0] fb,
                             input string tag);
      data_exp_t a, b;
      oe_exp_t   e;
      int        c;
      c = cyc;
      din   = d;
      oe_hr = oh;
      oe_fr = fa;
      a.due = c + 3; a.tag = tag;
      b.due = c + 4; b.tag = tag;
      for (int p = 0; p < PINS; p++) begin
         a.hi[p] = d[p*4+0]; a.lo[p] = d[p*4+1]; a.oe[p] = oh[p*2+0];
         b.hi[p] = d[p*4+2]; b.lo[p] = d[p*4+3]; b.oe[p] = oh[p*2+1];
      end
      q_data.push_back(a);
      q_data.push_back(b);
      e.due = c;     e.oe = fa; q_pass.push_back(e);
      e.due = c + 1; e.oe = fa; q_single.push_back(e);
      @(posedge clk_fast); #2;
      oe_fr = fb;
      e.due = c + 1; e.oe = fb; q_pass.push_back(e);
      e.due = c + 2; e.oe = fb; q_single.push_back(e);
      @(posedge clk_fast); #2;
   endtask

   // Monitor: high phase at edge+3 ns, low phase at edge+8 ns
   initial begin
      data_exp_t cur;
      oe_exp_t   o;
      bit        have;
      forever begin
         @(posedge clk_fast); #3;
         have = 1'b0;
         if (q_data.size() > 0 && q_data[0].due < cyc) begin
            void'(q_data.pop_front());
            chk("R2 expected data slot passed unchecked", 1'b1, 1'b0);
         end
         if (q_data.size() > 0 && q_data[0].due == cyc) begin
            cur  = q_data.pop_front();
            have = 1'b1;
            chk({cur.tag, " R1 R2 R3 even bit high phase"}, dout, cur.hi);
            chk({cur.tag, " R1 R3 even bit high phase (mode 0 unit)"}, dout_b, cur.hi);
            chk({cur.tag, " R1 R3 even bit high phase (mode 1 unit)"}, dout_p, cur.hi);
            chk({cur.tag, " R6 half-rate enable"}, oe_out, cur.oe);
         end
         if (q_pass.size() > 0 && q_pass[0].due == cyc) begin
            o = q_pass.pop_front();
            chk("R4 pass-through enable", oe_b, o.oe);
         end
         if (q_single.size() > 0 && q_single[0].due == cyc) begin
            o = q_single.pop_front();
            chk("R5 single-register enable", oe_p, o.oe);
         end
         #5;
         if (have) begin
            chk({cur.tag, " R1 R2 R3 odd bit low phase"}, dout, cur.lo);
            chk({cur.tag, " R1 R3 odd bit low phase (mode 0 unit)"}, dout_b, cur.lo);
            chk({cur.tag, " R1 R3 odd bit low phase (mode 1 unit)"}, dout_p, cur.lo);
            chk({cur.tag, " R6 half-rate enable held low phase"}, oe_out, cur.oe);
         end
      end
   end

   // Watchdog
   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired cyc=%0d", cyc);
      report();
      $finish;
   end

   initial begin
      // R7: reset state with every input driven high
      din   = '1;
      oe_hr = '1;
      oe_fr = '1;
      repeat (3) @(posedge clk_slow);
      #3;
      chk("R7 reset dout high phase", dout, '0);
      chk("R7 reset dout high phase (mode 0 unit)", dout_b, '0);
      chk("R7 reset enable half-rate", oe_out, '0);
      chk("R7 reset enable pass-through", oe_b, '0);
      chk("R7 reset enable single-register", oe_p, '0);
      #5;
      chk("R7 reset dout low phase", dout, '0);
      @(posedge clk_slow); #2;
      rst   = 1'b0;
      din   = '0;
      oe_hr = '0;
      oe_fr = '0;

      // Fixed patterns: alternating and complementary bits
      drive_slot(8'b1010_0101, 4'b10_01, 2'b01, 2'b10, "alt");
      drive_slot(8'b0101_1010, 4'b01_10, 2'b10, 2'b01, "alt");
      drive_slot(8'b1111_0000, 4'b11_00, 2'b11, 2'b00, "blk");
      drive_slot(8'b0000_1111, 4'b00_11, 2'b00, 2'b11, "blk");
      drive_slot(8'b0001_1000, 4'b01_00, 2'b01, 2'b01, "seq");

      // R8: a single set bit walks across every pin and position
      for (int k = 0; k < PINS*4; k++) begin
         drive_slot(8'(1 << k), 4'(1 << (k % (PINS*2))), 2'(1 << (k % PINS)),
                    2'b00, "R8 walk");
      end

      // Random traffic
      for (int k = 0; k < 40; k++) begin
         drive_slot(8'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), "rand");
      end

      // R7: reset in the middle of traffic, inputs held high
      drive_slot('1, '1, '1, '1, "ones");
      drive_slot('1, '1, '1, '1, "ones");
      repeat (2) @(posedge clk_slow);
      #2;
      rst = 1'b1;
      #1;
      chk("R7 pass-through enable drops at once", oe_b, '0);
      @(posedge clk_fast); #3;
      chk("R7 mid-run reset dout high phase", dout, '0);
      chk("R7 mid-run reset dout high phase (mode 1 unit)", dout_p, '0);
      chk("R7 mid-run reset enable half-rate", oe_out, '0);
      chk("R7 mid-run reset enable single-register", oe_p, '0);
      #5;
      chk("R7 mid-run reset dout low phase", dout, '0);
      @(posedge clk_slow); #2;
      rst = 1'b0;

      // Traffic resumes with correct alignment after reset
      for (int k = 0; k < 12; k++) begin
         drive_slot(8'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), "post");
      end

      repeat (6) @(posedge clk_fast);
      #4;
      chk("R2 scoreboard drained", PINS'(q_data.size()), '0);
      report();
      $finish;
   end

endmodule